// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous binary up-counter, four bits wide by default, that wraps to zero after its all-ones state. It can be preset from a parallel data bus, and it has two count enables with different roles. Counting needs both enables. Only the ripple enable takes part in the terminal-count flag. Because of this, a chain of stages can be built by feeding each stage's terminal-count flag into the ripple enable of the next stage, while one common gate enable pauses the whole chain.

A build-time parameter picks the clear style. In one style the active-low clear acts at once, without a clock edge. In the other style it takes effect on the next rising clock edge. Either way the block has a single clear port. The controls have a fixed precedence: clear, then preset, then count, then hold.

Top module: `preset_counter`

## Requirements
- R1: While `rst_n` is low at reset, `q` reads 0 and `tc` reads 0 in both clear styles.
- R2: With `rst_n`, `load_n`, `en_gate` and `en_ripple` all high, `q` increases by one on each rising clock edge.
- R3: A count from the all-ones value (15 at the default width) gives 0 on the next edge.
- R4: With `SYNC_RESET`=0, a low `rst_n` forces `q` to 0 at once, with no clock edge, and overrides every other input.
- R5: With `SYNC_RESET`=1, a low `rst_n` leaves `q` unchanged until the next rising edge. At that edge `q` becomes 0, overriding preset and count.
- R6: With `rst_n` high and `load_n` low, `din` is copied into `q` on the next rising edge, whatever the values of `en_gate` and `en_ripple`.
- R7: With `rst_n` and `load_n` high, `q` holds its value across an edge when either `en_gate` or `en_ripple` is low.
- R8: `tc` is 1 exactly when `en_ripple` is 1 and `q` is all ones. `en_gate` has no effect on `tc`. `tc` follows a change of `en_ripple` at once, with no clock edge.
- R9: Two stages, where the `tc` of the low stage drives the `en_ripple` of the high stage and both gate enables are tied high, count as one 8-bit counter with the value {high.q, low.q}, including past 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear. It is asynchronous or synchronous depending on `SYNC_RESET` |
| load_n | input | 1 | Active-low parallel preset |
| en_gate | input | 1 | Count enable that does not affect `tc` |
| en_ripple | input | 1 | Count enable that also qualifies `tc` |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal-count flag |

## Verification
A wrong stored count shows on `q` one edge after the faulty update, because every update is visible at the port. A wrong count is then carried forward: the next hold or count keeps the error until a preset or a clear overwrites it. An error in the mode precedence shows on the same edge as a preset or clear that arrives together with the enables. A flaw in the `tc` gating shows at once, without a clock, when `en_ripple` toggles while `q` is all ones. In a chain of stages, such a flaw shows as the high stage stepping at the wrong time.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
   typedef enum logic [1:0] {
      MODE_HOLD  = 2'd0,
      MODE_COUNT = 2'd1,
      MODE_LOAD  = 2'd2,
      MODE_CLEAR = 2'd3
   } ctr_mode_e;
endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
   import ctr_pkg::*;
#(
   parameter int SYNC_RESET = 0
) (
   input  logic      rst_n,
   input  logic      load_n,
   input  logic      en_gate,
   input  logic      en_ripple,
   output ctr_mode_e mode
);
   logic clr_req;

   // Only the clock-edge style treats clear as a register mode.
   assign clr_req = (SYNC_RESET != 0) && !rst_n;

   always_comb begin
      if (clr_req)                   mode = MODE_CLEAR;
      else if (!load_n)              mode = MODE_LOAD;
      else if (en_gate && en_ripple) mode = MODE_COUNT;
      else                           mode = MODE_HOLD;
   end
endmodule

// File: rtl/ctr_next_calc.sv
module ctr_next_calc
   import ctr_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  ctr_mode_e          mode,
   input  logic [WIDTH-1:0]   cur,
   input  logic [WIDTH-1:0]   din,
   output logic [WIDTH-1:0]   nxt
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_comb begin
      unique case (mode)
         MODE_CLEAR: nxt = '0;
         MODE_LOAD:  nxt = din;
         MODE_COUNT: nxt = cur + ONE;
         default:    nxt = cur;
      endcase
   end
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg #(
   parameter int WIDTH      = 4,
   parameter int SYNC_RESET = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (SYNC_RESET == 0) begin : g_async_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_sync_clr
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/ctr_term_det.sv
module ctr_term_det #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             en_ripple,
   output logic             tc
);
   assign tc = en_ripple & (&cur);
endmodule

// File: rtl/preset_counter.sv
module preset_counter
   import ctr_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter int SYNC_RESET = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic             en_gate,
   input  logic             en_ripple,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             tc
);
   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("preset_counter: WIDTH must lie in 1..32");
      end
      if (SYNC_RESET != 0 && SYNC_RESET != 1) begin : g_bad_style
         $error("preset_counter: SYNC_RESET must be 0 or 1");
      end
   endgenerate

   ctr_mode_e        mode;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] cur;

   ctr_mode_sel #(.SYNC_RESET(SYNC_RESET)) u_mode (
      .rst_n     (rst_n),
      .load_n    (load_n),
      .en_gate   (en_gate),
      .en_ripple (en_ripple),
      .mode      (mode)
   );

   ctr_next_calc #(.WIDTH(WIDTH)) u_next (
      .mode (mode),
      .cur  (cur),
      .din  (din),
      .nxt  (nxt)
   );

   ctr_state_reg #(.WIDTH(WIDTH), .SYNC_RESET(SYNC_RESET)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nxt),
      .q     (cur)
   );

   ctr_term_det #(.WIDTH(WIDTH)) u_tc (
      .cur       (cur),
      .en_ripple (en_ripple),
      .tc        (tc)
   );

   assign q = cur;
endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk #(
   parameter int WIDTH      = 4,
   parameter int SYNC_RESET = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_n,
   input logic             en_gate,
   input logic             en_ripple,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] q,
   input logic             tc
);
   localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};

   logic armed = 1'b0;
   always @(posedge clk) armed <= 1'b1;

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_gate && en_ripple) |=> (q == WIDTH'($past(q) + 1'b1)));

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_gate && en_ripple && q == ALL1) |=> (q == '0));

   assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n) |=> (q == $past(din)));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(en_gate && en_ripple)) |=> $stable(q));

   assert_tc_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (en_ripple && q == ALL1));

   assert_tc_needs_ripple_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_ripple && q == ALL1) |-> tc);

   generate
      if (SYNC_RESET == 0) begin : g_async_chk
         assert_clear_now_R4: assert property (@(posedge clk) disable iff (!armed)
            (!rst_n) |-> (q == '0 && !tc));
      end else begin : g_sync_chk
         assert_clear_edge_R5: assert property (@(posedge clk) disable iff (!armed)
            (!rst_n) |=> (q == '0));
      end
   endgenerate
endmodule

bind preset_counter preset_counter_chk #(.WIDTH(WIDTH), .SYNC_RESET(SYNC_RESET)) u_chk (.*);

// File: tb/preset_counter_test.sv
`timescale 1ns/1ps
module preset_counter_test;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0, load_n = 1'b0, en_gate = 1'b0, en_ripple = 1'b0;
   logic [3:0] din = 4'd0;
   logic [3:0] q_a, q_s;
   logic       tc_a, tc_s;

   logic       c_rst_n = 1'b0, c_en = 1'b0;
   logic [3:0] c_lo_q, c_hi_q;
   logic       c_lo_tc, c_hi_tc;

   int checks = 0;
   int failures = 0;
   logic [3:0] ma = 4'd0, ms = 4'd0;

   preset_counter #(.WIDTH(4), .SYNC_RESET(0)) uut (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_gate(en_gate),
      .en_ripple(en_ripple), .din(din), .q(q_a), .tc(tc_a));

   preset_counter #(.WIDTH(4), .SYNC_RESET(1)) uut_s (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_gate(en_gate),
      .en_ripple(en_ripple), .din(din), .q(q_s), .tc(tc_s));

   preset_counter #(.WIDTH(4), .SYNC_RESET(0)) c_lo (
      .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .en_gate(1'b1),
      .en_ripple(c_en), .din(4'd0), .q(c_lo_q), .tc(c_lo_tc));

   preset_counter #(.WIDTH(4), .SYNC_RESET(0)) c_hi (
      .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .en_gate(1'b1),
      .en_ripple(c_lo_tc), .din(4'd0), .q(c_hi_q), .tc(c_hi_tc));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [3:0] nxt(input logic [3:0] c, input logic r, l, p, t,
                                      input logic [3:0] d);
      if (!r)          return 4'd0;
      else if (!l)     return d;
      else if (p && t) return c + 4'd1;
      else             return c;
   endfunction

   function automatic string tag(input logic [3:0] c, input logic r, l, p, t,
                                 input logic sync);
      if (!r)          return sync ? "R5" : "R4";
      else if (!l)     return "R6";
      else if (p && t) return (c == 4'd15) ? "R3" : "R2";
      else             return "R7";
   endfunction

   task automatic step(input logic r, l, p, t, input logic [3:0] d);
      string ta, ts;
      @(negedge clk);
      rst_n = r; load_n = l; en_gate = p; en_ripple = t; din = d;
      if (!r) ma = 4'd0;
      #1;
      chk("R4 async clear before edge", q_a, ma);
      chk("R5 sync clear waits for edge", q_s, ms);
      chk("R8 tc async variant", tc_a, (t && ma == 4'd15));
      chk("R8 tc sync variant", tc_s, (t && ms == 4'd15));
      ta = tag(ma, r, l, p, t, 1'b0);
      ts = tag(ms, r, l, p, t, 1'b1);
      @(posedge clk);
      ma = nxt(ma, r, l, p, t, d);
      ms = nxt(ms, r, l, p, t, d);
      #1;
      chk({ta, " async variant after edge"}, q_a, ma);
      chk({ts, " sync variant after edge"}, q_s, ms);
   endtask

   initial begin
      #(5.0 * 150000);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int cnt;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset q async", q_a, 0);
      chk("R1 reset q sync", q_s, 0);
      chk("R1 reset tc async", tc_a, 0);
      chk("R1 reset tc sync", tc_s, 0);

      // R6/R8: preset 15 with gate low, ripple high -> tc at once
      step(1, 0, 0, 1, 4'd15);
      chk("R8 tc after preset 15", tc_a, 1);
      // R8: ripple low drops tc without clock, gate high irrelevant
      step(1, 1, 1, 0, 4'd0);
      // R3 wrap
      step(1, 1, 1, 1, 4'd3);
      chk("R3 wrapped to zero", q_a, 0);
      // R6 preset ignores enables, R7 holds
      step(1, 0, 1, 1, 4'd9);
      step(1, 1, 1, 0, 4'd2);
      step(1, 1, 0, 1, 4'd2);
      chk("R7 held value", q_a, 9);
      // R4/R5 clear overrides preset and count
      step(0, 0, 1, 1, 4'd5);
      chk("R5 sync cleared at edge", q_s, 0);
      step(1, 1, 1, 1, 4'd0);

      for (int i = 0; i < 500; i++) begin
         step(($urandom % 12) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
              ($urandom % 4) != 0, 4'($urandom));
      end

      // R9 cascade
      cnt = 0;
      @(negedge clk); c_rst_n = 1'b1;
      #1;
      chk("R9 cascade starts at zero", {c_hi_q, c_lo_q}, 0);
      for (int i = 0; i < 340; i++) begin
         @(negedge clk);
         c_en = ($urandom % 8) != 0;
         #1;
         chk("R9 high tc at 255", c_hi_tc, (c_en && cnt == 255));
         @(posedge clk);
         if (c_en) cnt = (cnt + 1) % 256;
         #1;
         chk("R9 cascaded count", {c_hi_q, c_lo_q}, cnt);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule